// File: doc/BRIEF.md
# Logical Shift-Right Execution Unit

This block executes the single-bit logical right shift of an 8/16-bit accumulator processor. On a start strobe it captures an opcode byte, the accumulator-width mode bit, the low byte of the direct-page base register, a 16-bit operand and the incoming status byte. From these it produces the shifted value, a new status byte and the number of bus cycles the instruction occupies. It also reports the instruction length for the five legal encodings.

A cycle timer then holds `busy` high for exactly that cycle count and pulses `done` for one clock afterwards. Results stay on the outputs until the next accepted start. Memory transactions, address generation and instruction fetch belong to neighbouring blocks. Those blocks use `busy`, `done`, `cycles` and `instr_len` to sequence their own work.

Top module: `lsr_exec_unit`

## Requirements
- R1: The result is the operand shifted one place toward bit 0, and the top bit of the active width becomes 0.
- R2: The carry flag (status bit 0) takes operand bit 0. The incoming carry never reaches the result or the new carry.
- R3: The status byte is laid out as N=bit7, V=bit6, M=bit5, X=bit4, D=bit3, I=bit2, Z=bit1, C=bit0. N is always cleared, Z is set exactly when the active-width result is zero, and bits 6 to 2 are copied from `flags_in`.
- R4: When `acc8` is 1 (8-bit mode), bit 7 is the top bit and bits 15:8 pass through unchanged. Z and C come from the low byte only. When `acc8` is 0, all 16 bits shift.
- R5: Legal opcodes and their `instr_len` values (the byte count) are: 0x4A accumulator, 1; 0x46 direct page, 2; 0x56 direct page indexed by X, 2; 0x4E absolute, 3; 0x5E absolute indexed by X, 3.
- R6: The base cycle counts are 2 for 0x4A, 5 for 0x46, 6 for 0x4E, 6 for 0x56 and 7 for 0x5E.
- R7: With `acc8`=0, every legal opcode except 0x4A adds 2 cycles.
- R8: 0x46 and 0x56 add 1 more cycle when `dp_low` is nonzero.
- R9: After an accepted legal start, `busy` rises on the next clock and stays high for exactly `cycles` clocks. `done` is then high for the single clock after `busy` falls.
- R10: A start with any other opcode sets `illegal`. It leaves `result`, `flags_out`, `cycles` and `instr_len` unchanged and raises neither `busy` nor `done`.
- R11: A start while `busy` is high is ignored, so the outputs and the running count are not disturbed.
- R12: Reset clears `busy`, `done` and `illegal`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Capture inputs and begin an instruction |
| opcode | input | 8 | Opcode byte |
| acc8 | input | 1 | 1 = 8-bit accumulator, 0 = 16-bit |
| dp_low | input | 8 | Low byte of the direct-page base |
| operand | input | 16 | Value to shift |
| flags_in | input | 8 | Incoming status byte |
| result | output | 16 | Shifted value |
| flags_out | output | 8 | Updated status byte |
| cycles | output | 4 | Total cycle count of the instruction |
| instr_len | output | 2 | Instruction length in bytes |
| busy | output | 1 | High for the instruction's cycle count |
| done | output | 1 | One-clock pulse after busy ends |
| illegal | output | 1 | Last accepted opcode was not legal |

## Verification
`result`, `flags_out`, `cycles`, `instr_len` and `illegal` are registered on the clock edge that samples `start`, and `busy` rises on that same edge. The bench drives inputs on falling edges and reads every output on the falling edge that follows the capturing rising edge. It then counts falling edges while `busy` is high and compares that count with the cycle total computed from the opcode table. It expects `done` on the first falling edge where `busy` is low and requires `done` to be clear again one edge later.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
  localparam int DATA_W   = 16;
  localparam int NARROW_W = 8;
  localparam int CNT_W    = 4;
  localparam int LEN_W    = 2;
  localparam int OPC_W    = 8;
  localparam int FLAG_W   = 8;

  localparam int FLG_N = 7;
  localparam int FLG_Z = 1;
  localparam int FLG_C = 0;

  typedef enum logic [2:0] {
    AM_ACC,
    AM_ABS,
    AM_DIR,
    AM_ABS_X,
    AM_DIR_X,
    AM_BAD
  } addr_mode_e;

  typedef struct packed {
    logic             legal;
    logic [LEN_W-1:0] len;
    logic [CNT_W-1:0] cycles;
  } decode_t;
endpackage

// File: rtl/lsr_decode.sv
module lsr_decode
  import lsr_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  input  logic             acc8,
  input  logic [7:0]       dp_low,
  output decode_t          dec
);
  addr_mode_e       mode;
  logic [CNT_W-1:0] base;
  logic [CNT_W-1:0] width_pen;
  logic [CNT_W-1:0] align_pen;
  logic             is_dir;

  always_comb begin
    unique case (opcode)
      8'h4A:   mode = AM_ACC;
      8'h4E:   mode = AM_ABS;
      8'h46:   mode = AM_DIR;
      8'h5E:   mode = AM_ABS_X;
      8'h56:   mode = AM_DIR_X;
      default: mode = AM_BAD;
    endcase
  end

  always_comb begin
    base       = '0;
    dec.len    = '0;
    dec.legal  = 1'b1;
    is_dir     = 1'b0;
    unique case (mode)
      AM_ACC:   begin base = CNT_W'(2); dec.len = LEN_W'(1); end
      AM_ABS:   begin base = CNT_W'(6); dec.len = LEN_W'(3); end
      AM_DIR:   begin base = CNT_W'(5); dec.len = LEN_W'(2); is_dir = 1'b1; end
      AM_ABS_X: begin base = CNT_W'(7); dec.len = LEN_W'(3); end
      AM_DIR_X: begin base = CNT_W'(6); dec.len = LEN_W'(2); is_dir = 1'b1; end
      default:  dec.legal = 1'b0;
    endcase
  end

  // Wide-accumulator penalty applies to memory forms only.
  assign width_pen  = (!acc8 && dec.legal && mode != AM_ACC) ? CNT_W'(2) : '0;
  // Misaligned direct page costs one extra cycle.
  assign align_pen  = (is_dir && (dp_low != 8'h00)) ? CNT_W'(1) : '0;
  assign dec.cycles = base + width_pen + align_pen;
endmodule

// File: rtl/lsr_shifter.sv
module lsr_shifter
  import lsr_pkg::*;
#(
  parameter int W  = DATA_W,
  parameter int NW = NARROW_W
) (
  input  logic [W-1:0]      operand,
  input  logic              narrow,
  input  logic [FLAG_W-1:0] flags_in,
  output logic [W-1:0]      shifted,
  output logic [FLAG_W-1:0] flags_new
);
  logic zero_wide;
  logic zero_narrow;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_lane
      if (i == W - 1) begin : g_top
        if (i == NW - 1) begin : g_same
          assign shifted[i] = 1'b0;
        end else begin : g_wide_top
          assign shifted[i] = narrow ? operand[i] : 1'b0;
        end
      end else if (i == NW - 1) begin : g_narrow_top
        assign shifted[i] = narrow ? 1'b0 : operand[i+1];
      end else if (i >= NW) begin : g_upper
        assign shifted[i] = narrow ? operand[i] : operand[i+1];
      end else begin : g_lower
        assign shifted[i] = operand[i+1];
      end
    end
  endgenerate

  assign zero_wide   = ~|shifted;
  assign zero_narrow = ~|shifted[NW-1:0];

  always_comb begin
    flags_new        = flags_in;
    flags_new[FLG_N] = 1'b0;
    flags_new[FLG_Z] = narrow ? zero_narrow : zero_wide;
    flags_new[FLG_C] = operand[0];
  end
endmodule

// File: rtl/lsr_cycle_timer.sv
module lsr_cycle_timer
  import lsr_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          busy,
  output logic          done
);
  logic [CW-1:0] remain_q, remain_d;
  logic          busy_d, done_d;
  logic          en;

  always_comb begin
    remain_d = remain_q;
    busy_d   = busy;
    done_d   = 1'b0;
    if (busy) begin
      if (remain_q == '0) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        remain_d = remain_q - CW'(1);
      end
    end else if (load) begin
      busy_d   = 1'b1;
      remain_d = load_val - CW'(1);
    end
  end

  assign en = busy | load | done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain_q <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
    end else if (en) begin
      remain_q <= remain_d;
      busy     <= busy_d;
      done     <= done_d;
    end
  end
endmodule

// File: rtl/lsr_exec_unit.sv
module lsr_exec_unit
  import lsr_pkg::*;
#(
  parameter int W  = DATA_W,
  parameter int NW = NARROW_W,
  parameter int CW = CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [OPC_W-1:0]  opcode,
  input  logic              acc8,
  input  logic [7:0]        dp_low,
  input  logic [W-1:0]      operand,
  input  logic [FLAG_W-1:0] flags_in,
  output logic [W-1:0]      result,
  output logic [FLAG_W-1:0] flags_out,
  output logic [CW-1:0]     cycles,
  output logic [LEN_W-1:0]  instr_len,
  output logic              busy,
  output logic              done,
  output logic              illegal
);
  decode_t           dec;
  logic [W-1:0]      shifted;
  logic [FLAG_W-1:0] flags_new;
  logic              accept;
  logic              load_ok;

  logic [W-1:0]      result_d;
  logic [FLAG_W-1:0] flags_d;
  logic [CW-1:0]     cycles_d;
  logic [LEN_W-1:0]  len_d;
  logic              illegal_d;

  lsr_decode u_dec (
    .opcode (opcode),
    .acc8   (acc8),
    .dp_low (dp_low),
    .dec    (dec)
  );

  lsr_shifter #(.W(W), .NW(NW)) u_shift (
    .operand   (operand),
    .narrow    (acc8),
    .flags_in  (flags_in),
    .shifted   (shifted),
    .flags_new (flags_new)
  );

  assign accept  = start & ~busy;
  assign load_ok = accept & dec.legal;

  lsr_cycle_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_ok),
    .load_val (CW'(dec.cycles)),
    .busy     (busy),
    .done     (done)
  );

  always_comb begin
    result_d  = result;
    flags_d   = flags_out;
    cycles_d  = cycles;
    len_d     = instr_len;
    illegal_d = illegal;
    if (accept) begin
      illegal_d = ~dec.legal;
      if (dec.legal) begin
        result_d = shifted;
        flags_d  = flags_new;
        cycles_d = CW'(dec.cycles);
        len_d    = dec.len;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result    <= '0;
      flags_out <= '0;
      cycles    <= '0;
      instr_len <= '0;
      illegal   <= 1'b0;
    end else if (accept) begin
      result    <= result_d;
      flags_out <= flags_d;
      cycles    <= cycles_d;
      instr_len <= len_d;
      illegal   <= illegal_d;
    end
  end
endmodule

// File: rtl/lsr_exec_unit_chk.sv
module lsr_exec_unit_chk
  import lsr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              illegal,
  input logic [FLAG_W-1:0] flags_out,
  input logic [DATA_W-1:0] result,
  input logic [CNT_W-1:0]  cycles
);
  logic [7:0] busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_run <= '0;
    else if (busy) busy_run <= busy_run + 8'd1;
    else busy_run <= '0;
  end

  p_busy_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_run == 8'(cycles)));

  p_done_after_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_n_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !flags_out[FLG_N]);

  p_illegal_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!busy && !done));

  p_start_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(result) && $stable(flags_out) && $stable(cycles)));
endmodule

bind lsr_exec_unit lsr_exec_unit_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .illegal   (illegal),
  .flags_out (flags_out),
  .result    (result),
  .cycles    (cycles)
);

// File: tb/lsr_exec_unit_tb_top.sv
`timescale 1ns/1ps
module lsr_exec_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [7:0]  opcode;
  logic        acc8;
  logic [7:0]  dp_low;
  logic [15:0] operand;
  logic [7:0]  flags_in;
  logic [15:0] result;
  logic [7:0]  flags_out;
  logic [3:0]  cycles;
  logic [1:0]  instr_len;
  logic        busy, done, illegal;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  lsr_exec_unit dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .acc8(acc8),
    .dp_low(dp_low), .operand(operand), .flags_in(flags_in), .result(result),
    .flags_out(flags_out), .cycles(cycles), .instr_len(instr_len),
    .busy(busy), .done(done), .illegal(illegal)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int exp_cycles(input logic [7:0] op, input logic a8, input logic [7:0] dp);
    int c;
    case (op)
      8'h4A: c = 2; 8'h4E: c = 6; 8'h46: c = 5; 8'h5E: c = 7; 8'h56: c = 6;
      default: c = 0;
    endcase
    if (op != 8'h4A && !a8) c += 2;                       // R7
    if ((op == 8'h46 || op == 8'h56) && dp != 0) c += 1;  // R8
    return c;
  endfunction

  function automatic int exp_len(input logic [7:0] op);
    case (op)
      8'h4A: return 1;
      8'h46, 8'h56: return 2;
      default: return 3;
    endcase
  endfunction

  task automatic pulse_start(input logic [7:0] op, input logic a8, input logic [7:0] dp,
                             input logic [15:0] val, input logic [7:0] fl);
    @(negedge clk);
    opcode = op; acc8 = a8; dp_low = dp; operand = val; flags_in = fl; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // Counts busy cycles from the current negedge, checks done pulse.
  task automatic check_timing(input int exp_n, input string tag);
    int n = 0;
    while (busy && n < 40) begin
      n++;
      @(negedge clk);
    end
    check(n == exp_n, {tag, " R9 busy length"}, n, exp_n);
    check(done == 1'b1, {tag, " R9 done pulse"}, done, 1);
    @(negedge clk);
    check(done == 1'b0, {tag, " R9 done single"}, done, 0);
  endtask

  task automatic run_op(input logic [7:0] op, input logic a8, input logic [7:0] dp,
                        input logic [15:0] val, input logic [7:0] fl, input string tag);
    logic [15:0] er;
    logic [7:0]  ef;
    logic        z;
    if (a8) begin
      er = {val[15:8], 1'b0, val[7:1]};  // R4
      z  = (er[7:0] == 8'h00);
    end else begin
      er = {1'b0, val[15:1]};            // R1
      z  = (er == 16'h0000);
    end
    ef = {1'b0, fl[6:2], z, val[0]};     // R2 R3
    pulse_start(op, a8, dp, val, fl);
    check(result == er, {tag, " R1 R4 result"}, result, er);
    check(flags_out == ef, {tag, " R2 R3 flags"}, flags_out, ef);
    check(cycles == exp_cycles(op, a8, dp), {tag, " R6 R7 R8 cycles"}, cycles, exp_cycles(op, a8, dp));
    check(instr_len == exp_len(op), {tag, " R5 length"}, instr_len, exp_len(op));
    check(illegal == 1'b0, {tag, " R10 legal"}, illegal, 0);
    check_timing(exp_cycles(op, a8, dp), tag);
  endtask

  task automatic t_reset();
    check(busy == 0 && done == 0 && illegal == 0, "R12 reset state", {busy, done, illegal}, 0);
  endtask

  task automatic t_illegal();
    logic [15:0] r0 = result;
    logic [7:0]  f0 = flags_out;
    logic [3:0]  c0 = cycles;
    pulse_start(8'h4B, 1'b0, 8'h00, 16'hFFFF, 8'hFF);
    check(illegal == 1'b1, "R10 illegal flag", illegal, 1);
    check(result == r0, "R10 result kept", result, r0);
    check(flags_out == f0, "R10 flags kept", flags_out, f0);
    check(cycles == c0, "R10 cycles kept", cycles, c0);
    for (int k = 0; k < 4; k++) begin
      check(!busy && !done, "R10 no busy", {busy, done}, 0);
      @(negedge clk);
    end
  endtask

  task automatic t_busy_start();
    logic [15:0] r0;
    int n = 1;
    pulse_start(8'h5E, 1'b0, 8'h00, 16'h8002, 8'h00);  // 9 cycles
    r0 = result;
    @(negedge clk);
    opcode = 8'h4A; operand = 16'h0003; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 2;
    check(result == r0, "R11 result unchanged", result, r0);
    check(cycles == 4'd9, "R11 cycles unchanged", cycles, 9);
    while (busy && n < 40) begin
      n++;
      @(negedge clk);
    end
    check(n == 9, "R11 busy count undisturbed", n, 9);
    check(done == 1'b1, "R11 done", done, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; opcode = 8'h00; acc8 = 1'b0;
    dp_low = 8'h00; operand = 16'h0000; flags_in = 8'h00;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    run_op(8'h4A, 1'b0, 8'h00, 16'hA5A5, 8'hFE, "acc16");
    run_op(8'h4A, 1'b1, 8'h12, 16'hBE81, 8'h80, "acc8");
    run_op(8'h4E, 1'b0, 8'h00, 16'h0002, 8'h01, "abs16 carry-in dropped");
    run_op(8'h4E, 1'b1, 8'h00, 16'h1234, 8'h7C, "abs8");
    run_op(8'h46, 1'b1, 8'h00, 16'h0001, 8'h00, "dp8 aligned zero");
    run_op(8'h46, 1'b0, 8'h01, 16'h8000, 8'h44, "dp16 misaligned");
    run_op(8'h5E, 1'b1, 8'h05, 16'hFFFF, 8'h00, "absx8");
    run_op(8'h5E, 1'b0, 8'h05, 16'h0001, 8'h00, "absx16 zero");
    run_op(8'h56, 1'b1, 8'h80, 16'h7F01, 8'h00, "dpx8 upper pass");
    run_op(8'h56, 1'b0, 8'h00, 16'h4321, 8'h3C, "dpx16 aligned");
    run_op(8'h56, 1'b0, 8'hFF, 16'hFFFE, 8'h00, "dpx16 misaligned");
    t_illegal();
    run_op(8'h4A, 1'b0, 8'h00, 16'h0100, 8'h00, "after illegal");
    t_busy_start();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    t_reset();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule